// File: doc/BRIEF.md
# Program Sequencer with Branch Delay Slot

This block owns the program counter of a small 16-bit processor and decides which word is fetched next. Instruction memory is read without a clock cycle of latency, so the word at `fetch_addr_o` is decoded and presented back to the block in the same cycle as a control-flow opcode plus operands: a register value, an offset field, a condition result and the raw program-memory word. Every transfer of control, whether taken jump, branch, call or return, is followed by exactly one delay-slot instruction before the new address takes effect. Relative targets are measured from the delay-slot address.

Calls push a return address onto an external stack, and returns pop it back. The return address is the word after the delay slot. Immediate jump and call forms spend one fetch cycle reading their target from the following program word. An accepted interrupt annuls the instruction being fetched and pushes its address. It then switches to the shadow register set, clears the interrupt enable and vectors to a fixed address. Return from interrupt pops the stack and switches back to the normal register set. A halt instruction parks the sequencer until a wake-up pulse arrives or an enabled interrupt is accepted.

The controller has four states. `ST_RUN` executes ordinary instructions. `ST_IMM` fetches the target word of an immediate form. `ST_SLOT` executes the delay-slot instruction. `ST_HALT` waits. The transitions are:
- RUN→SLOT on a taken transfer.
- RUN→IMM on an immediate jump or call.
- RUN→HALT on halt.
- IMM→SLOT always.
- SLOT→RUN always.
- HALT→RUN on wake-up or an accepted interrupt.
- RUN→RUN on an accepted interrupt.

Top module: `seq_pcu`

## Requirements
- R1: After reset the fetch address is 0x0000, `exec_o` is 1, the interrupt enable is 0 and the shadow select is 0.
- R2: Opcodes that do not transfer control (code 0 no-op, 12 enable, 13 disable, 14 and 15) advance the fetch address by one on the next cycle.
- R3: A register jump (code 1) at address A fetches and executes A+1 next, then fetches the register value.
- R4: The long relative jump (code 3) and call (code 6) target A+1 plus `offset_i[11:0]` sign-extended. The relative branch (code 10) targets A+1 plus `offset_i[7:0]` sign-extended, and `offset_i[11:8]` is ignored.
- R5: A register branch (code 9) or relative branch (code 10) with `cond_i`=0 falls through to A+1 and then A+2 with no transfer.
- R6: Immediate jump (code 2) or call (code 5) at A fetches A+1 with `exec_o`=0 and takes `prog_data_i` from that cycle as the target. It then executes the delay slot at A+2.
- R7: Register call (code 4) and relative call (code 6) at A assert `stk_push_o` in that cycle with write data A+2. The immediate call asserts it in its operand cycle with write data A+3. Push and pop never coincide.
- R8: Return (code 7) and return-from-interrupt (code 8) assert `stk_pop_o` and transfer to `stk_rdata_i` after the delay slot. Return-from-interrupt also clears `shadow_o` from the next cycle.
- R9: Halt (code 11) at A holds the fetch address at A+1 with `exec_o`=0 until `wake_i` is high. On the cycle after that, A+1 executes.
- R10: When `irq_i` is high and the enable is set, in run or halt, `exec_o` is 0, the current fetch address is pushed, and on the next cycle the fetch address is 0x0004, `shadow_o` is 1 and the enable is 0.
- R11: No interrupt is accepted during a delay-slot or immediate-operand cycle. The interrupt is taken at the transfer target instead.
- R12: Enable (code 12) sets and disable (code 13) clears `irq_en_o` from the next cycle. With the enable clear, `irq_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Decoded control-flow opcode of the word at `fetch_addr_o` |
| offset_i | input | 12 | Immediate offset field of that word |
| cond_i | input | 1 | Branch condition result |
| reg_i | input | 16 | Register operand for register-target forms |
| prog_data_i | input | 16 | Raw program-memory word at `fetch_addr_o` |
| stk_rdata_i | input | 16 | Top-of-stack read data |
| irq_i | input | 1 | Interrupt request |
| wake_i | input | 1 | Wake-up from halt |
| fetch_addr_o | output | 16 | Program fetch address |
| exec_o | output | 1 | The word at `fetch_addr_o` executes this cycle |
| stk_push_o | output | 1 | Push `stk_wdata_o` onto the stack |
| stk_pop_o | output | 1 | Pop the stack |
| stk_wdata_o | output | 16 | Stack write data (return address) |
| irq_en_o | output | 1 | Interrupt enable |
| shadow_o | output | 1 | Shadow register set selected |

## Verification
The assertions assume the decoder never places a control-transfer opcode in a delay slot. They also assume the stack read data is valid whenever a return is decoded. The directed tasks keep to this by putting only no-ops, enable or disable in every slot, and by driving `stk_rdata_i` alongside each return opcode. Interrupt and wake-up requests are raised only at instruction boundaries chosen by each task, so every acceptance cycle is known in advance.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_JMP  = 4'd1,
        OP_JMPI = 4'd2,
        OP_JMPR = 4'd3,
        OP_JSR  = 4'd4,
        OP_JSRI = 4'd5,
        OP_JSRR = 4'd6,
        OP_RTS  = 4'd7,
        OP_RTI  = 4'd8,
        OP_BRA  = 4'd9,
        OP_BRAR = 4'd10,
        OP_HALT = 4'd11,
        OP_EI   = 4'd12,
        OP_DI   = 4'd13,
        OP_RS14 = 4'd14,
        OP_RS15 = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_IMM  = 2'd1,
        ST_SLOT = 2'd2,
        ST_HALT = 2'd3
    } state_e;

endpackage

// File: rtl/seq_target.sv
module seq_target
    import seq_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int LONG_W  = 12,
    parameter int SHORT_W = 8
) (
    input  op_e               op_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PC_W-1:0]   reg_i,
    input  logic [PC_W-1:0]   stk_i,
    input  logic [LONG_W-1:0] off_i,
    output logic [PC_W-1:0]   tgt_o
);
    localparam int LONG_PAD  = PC_W - LONG_W;
    localparam int SHORT_PAD = PC_W - SHORT_W;

    logic [PC_W-1:0] slot_addr;
    logic [PC_W-1:0] long_ext;
    logic [PC_W-1:0] short_ext;

    assign slot_addr = pc_i + {{(PC_W-1){1'b0}}, 1'b1};
    assign long_ext  = {{LONG_PAD{off_i[LONG_W-1]}}, off_i};
    assign short_ext = {{SHORT_PAD{off_i[SHORT_W-1]}}, off_i[SHORT_W-1:0]};

    always_comb begin
        case (op_i)
            OP_JMPR, OP_JSRR: tgt_o = slot_addr + long_ext;
            OP_BRAR:          tgt_o = slot_addr + short_ext;
            OP_RTS, OP_RTI:   tgt_o = stk_i;
            default:          tgt_o = reg_i;
        endcase
    end
endmodule

// File: rtl/seq_irq_ctl.sv
module seq_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic set_en_i,
    input  logic clr_en_i,
    input  logic leave_shadow_i,
    output logic irq_en_o,
    output logic shadow_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_o <= 1'b0;
            shadow_o <= 1'b0;
        end else if (take_i) begin
            irq_en_o <= 1'b0;
            shadow_o <= 1'b1;
        end else begin
            if (set_en_i)       irq_en_o <= 1'b1;
            else if (clr_en_i)  irq_en_o <= 1'b0;
            if (leave_shadow_i) shadow_o <= 1'b0;
        end
    end
endmodule

// File: rtl/seq_pcu.sv
module seq_pcu
    import seq_pkg::*;
#(
    parameter int              PC_W    = 16,
    parameter int              LONG_W  = 12,
    parameter int              SHORT_W = 8,
    parameter logic [PC_W-1:0] IRQ_VEC = 16'h0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [LONG_W-1:0] offset_i,
    input  logic              cond_i,
    input  logic [PC_W-1:0]   reg_i,
    input  logic [PC_W-1:0]   prog_data_i,
    input  logic [PC_W-1:0]   stk_rdata_i,
    input  logic              irq_i,
    input  logic              wake_i,
    output logic [PC_W-1:0]   fetch_addr_o,
    output logic              exec_o,
    output logic              stk_push_o,
    output logic              stk_pop_o,
    output logic [PC_W-1:0]   stk_wdata_o,
    output logic              irq_en_o,
    output logic              shadow_o
);
    localparam logic [PC_W-1:0] STEP1 = PC_W'(1);
    localparam logic [PC_W-1:0] STEP2 = PC_W'(2);

    state_e          state_q, state_d;
    logic [PC_W-1:0] pc_q, pc_d;
    logic [PC_W-1:0] tgt_q, tgt_d;
    logic            call_q, call_d;
    logic [PC_W-1:0] tgt_calc;
    logic            irq_take;
    logic            set_en, clr_en, leave_shadow;
    op_e             op;

    assign op = op_e'(op_i);

    seq_target #(.PC_W(PC_W), .LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_target (
        .op_i  (op),
        .pc_i  (pc_q),
        .reg_i (reg_i),
        .stk_i (stk_rdata_i),
        .off_i (offset_i),
        .tgt_o (tgt_calc)
    );

    seq_irq_ctl u_irq (
        .clk            (clk),
        .rst_n          (rst_n),
        .take_i         (irq_take),
        .set_en_i       (set_en),
        .clr_en_i       (clr_en),
        .leave_shadow_i (leave_shadow),
        .irq_en_o       (irq_en_o),
        .shadow_o       (shadow_o)
    );

    assign irq_take = irq_i && irq_en_o && (state_q == ST_RUN || state_q == ST_HALT);
    assign fetch_addr_o = pc_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pc_q    <= '0;
            tgt_q   <= '0;
            call_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            tgt_q   <= tgt_d;
            call_q  <= call_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d      = state_q;
        pc_d         = pc_q;
        tgt_d        = tgt_q;
        call_d       = call_q;
        exec_o       = 1'b0;
        stk_push_o   = 1'b0;
        stk_pop_o    = 1'b0;
        stk_wdata_o  = pc_q + STEP2;
        set_en       = 1'b0;
        clr_en       = 1'b0;
        leave_shadow = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (irq_take) begin
                    stk_push_o  = 1'b1;
                    stk_wdata_o = pc_q;
                    pc_d        = IRQ_VEC;
                end else begin
                    exec_o = 1'b1;
                    pc_d   = pc_q + STEP1;
                    tgt_d  = tgt_calc;
                    case (op)
                        OP_JMP, OP_JMPR: state_d = ST_SLOT;
                        OP_JSR, OP_JSRR: begin
                            stk_push_o = 1'b1;
                            state_d    = ST_SLOT;
                        end
                        OP_JMPI: begin
                            call_d  = 1'b0;
                            state_d = ST_IMM;
                        end
                        OP_JSRI: begin
                            call_d  = 1'b1;
                            state_d = ST_IMM;
                        end
                        OP_RTS: begin
                            stk_pop_o = 1'b1;
                            state_d   = ST_SLOT;
                        end
                        OP_RTI: begin
                            stk_pop_o    = 1'b1;
                            leave_shadow = 1'b1;
                            state_d      = ST_SLOT;
                        end
                        OP_BRA, OP_BRAR: if (cond_i) state_d = ST_SLOT;
                        OP_HALT: state_d = ST_HALT;
                        OP_EI:   set_en = 1'b1;
                        OP_DI:   clr_en = 1'b1;
                        default: ;
                    endcase
                end
            end
            ST_IMM: begin
                pc_d       = pc_q + STEP1;
                tgt_d      = prog_data_i;
                stk_push_o = call_q;
                state_d    = ST_SLOT;
            end
            ST_SLOT: begin
                exec_o  = 1'b1;
                pc_d    = tgt_q;
                state_d = ST_RUN;
                if (op == OP_EI) set_en = 1'b1;
                if (op == OP_DI) clr_en = 1'b1;
            end
            ST_HALT: begin
                if (irq_take) begin
                    stk_push_o  = 1'b1;
                    stk_wdata_o = pc_q;
                    pc_d        = IRQ_VEC;
                    state_d     = ST_RUN;
                end else if (wake_i) begin
                    state_d = ST_RUN;
                end
            end
        endcase
    end
endmodule

// File: rtl/seq_pcu_chk.sv
module seq_pcu_chk
    import seq_pkg::*;
#(
    parameter int              PC_W    = 16,
    parameter logic [PC_W-1:0] IRQ_VEC = 16'h0004
) (
    input logic            clk,
    input logic            rst_n,
    input state_e          state_q,
    input logic            irq_take,
    input logic [3:0]      op_i,
    input logic            wake_i,
    input logic [PC_W-1:0] fetch_addr_o,
    input logic            exec_o,
    input logic            stk_push_o,
    input logic            stk_pop_o,
    input logic [PC_W-1:0] stk_wdata_o,
    input logic            irq_en_o,
    input logic            shadow_o
);
    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    logic plain_op;
    assign plain_op = (op_i == 4'd0) || (op_i >= 4'd12);

    // R2
    a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && exec_o && plain_op) |=> fetch_addr_o == $past(fetch_addr_o) + ONE);

    // R7
    a_r7_push_pop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_push_o && stk_pop_o));

    // R9
    a_r9_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !wake_i && !irq_take) |=> ($stable(fetch_addr_o) && !exec_o));

    // R10
    a_r10_irq_push: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (stk_push_o && !exec_o && stk_wdata_o == fetch_addr_o));

    // R10
    a_r10_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> (fetch_addr_o == IRQ_VEC && shadow_o && !irq_en_o));

    // R11
    a_r11_no_irq_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLOT || state_q == ST_IMM) |-> !irq_take);

    // R12
    a_r12_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_o && op_i == 4'd12) |=> irq_en_o);
endmodule

bind seq_pcu seq_pcu_chk #(.PC_W(PC_W), .IRQ_VEC(IRQ_VEC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (state_q),
    .irq_take     (irq_take),
    .op_i         (op_i),
    .wake_i       (wake_i),
    .fetch_addr_o (fetch_addr_o),
    .exec_o       (exec_o),
    .stk_push_o   (stk_push_o),
    .stk_pop_o    (stk_pop_o),
    .stk_wdata_o  (stk_wdata_o),
    .irq_en_o     (irq_en_o),
    .shadow_o     (shadow_o)
);

// File: tb/seq_pcu_tb.sv
module seq_pcu_tb;
    import seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [11:0] offset_i = '0;
    logic        cond_i = 1'b0;
    logic [15:0] reg_i = '0;
    logic [15:0] prog_data_i = '0;
    logic [15:0] stk_rdata_i = '0;
    logic        irq_i = 1'b0;
    logic        wake_i = 1'b0;
    logic [15:0] fetch_addr_o;
    logic        exec_o, stk_push_o, stk_pop_o, irq_en_o, shadow_o;
    logic [15:0] stk_wdata_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    seq_pcu u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .offset_i(offset_i), .cond_i(cond_i),
        .reg_i(reg_i), .prog_data_i(prog_data_i), .stk_rdata_i(stk_rdata_i),
        .irq_i(irq_i), .wake_i(wake_i), .fetch_addr_o(fetch_addr_o), .exec_o(exec_o),
        .stk_push_o(stk_push_o), .stk_pop_o(stk_pop_o), .stk_wdata_o(stk_wdata_o),
        .irq_en_o(irq_en_o), .shadow_o(shadow_o)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        op_i = 4'd0; offset_i = '0; cond_i = 1'b0; reg_i = '0;
        prog_data_i = '0; stk_rdata_i = '0; irq_i = 1'b0; wake_i = 1'b0;
    endtask

    // set opcode, let combinational outputs settle
    task automatic drive(op_e op);
        op_i = op;
        #1;
    endtask

    // advance one clock, land on the next falling edge, clear inputs
    task automatic step();
        @(negedge clk);
        idle_inputs();
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_inputs();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 addr", 32'(fetch_addr_o), 32'h0);
        chk("R1 exec", 32'(exec_o), 32'h1);
        chk("R1 irq_en", 32'(irq_en_o), 32'h0);
        chk("R1 shadow", 32'(shadow_o), 32'h0);
    endtask

    task automatic t_sequential();
        do_reset();
        drive(OP_NOP); step();
        drive(OP_RS14); step();
        drive(OP_DI); step();
        chk("R2 addr after 3", 32'(fetch_addr_o), 32'h3);
    endtask

    task automatic t_jump();
        do_reset();
        reg_i = 16'h1234; drive(OP_JMP); step();
        chk("R3 slot addr", 32'(fetch_addr_o), 32'h1);
        chk("R3 slot exec", 32'(exec_o), 32'h1);
        drive(OP_NOP); step();
        chk("R3 target", 32'(fetch_addr_o), 32'h1234);
    endtask

    task automatic t_relative();
        do_reset();
        drive(OP_NOP); step();
        drive(OP_NOP); step();
        offset_i = 12'hFFE; drive(OP_JMPR); step();
        drive(OP_NOP); step();
        chk("R4 long back", 32'(fetch_addr_o), 32'h1);
        offset_i = 12'h7F0; cond_i = 1'b1; drive(OP_BRAR); step();
        drive(OP_NOP); step();
        chk("R4 short back", 32'(fetch_addr_o), 32'hFFF2);
    endtask

    task automatic t_branch_not_taken();
        do_reset();
        reg_i = 16'h0800; cond_i = 1'b0; drive(OP_BRA); step();
        chk("R5 fall 1", 32'(fetch_addr_o), 32'h1);
        offset_i = 12'h010; cond_i = 1'b0; drive(OP_BRAR); step();
        chk("R5 fall 2", 32'(fetch_addr_o), 32'h2);
    endtask

    task automatic t_immediate();
        do_reset();
        drive(OP_JMPI); step();
        prog_data_i = 16'h0400; drive(OP_NOP);
        chk("R6 operand exec", 32'(exec_o), 32'h0);
        chk("R6 operand addr", 32'(fetch_addr_o), 32'h1);
        step();
        drive(OP_NOP);
        chk("R6 slot addr", 32'(fetch_addr_o), 32'h2);
        chk("R6 slot exec", 32'(exec_o), 32'h1);
        step();
        chk("R6 target", 32'(fetch_addr_o), 32'h0400);
        drive(OP_JSRI); step();
        prog_data_i = 16'h0100; drive(OP_NOP);
        chk("R7 imm call push", 32'(stk_push_o), 32'h1);
        chk("R7 imm call data", 32'(stk_wdata_o), 32'h0403);
        step();
        drive(OP_NOP); step();
        chk("R6 call target", 32'(fetch_addr_o), 32'h0100);
    endtask

    task automatic t_call_return();
        do_reset();
        offset_i = 12'h005; drive(OP_JSRR);
        chk("R7 push", 32'(stk_push_o), 32'h1);
        chk("R7 data", 32'(stk_wdata_o), 32'h2);
        step();
        drive(OP_NOP); step();
        chk("R4 call target", 32'(fetch_addr_o), 32'h6);
        stk_rdata_i = 16'h0002; drive(OP_RTS);
        chk("R8 pop", 32'(stk_pop_o), 32'h1);
        chk("R7 no push on pop", 32'(stk_push_o), 32'h0);
        step();
        chk("R8 slot", 32'(fetch_addr_o), 32'h7);
        drive(OP_NOP); step();
        chk("R8 return", 32'(fetch_addr_o), 32'h2);
    endtask

    task automatic t_interrupt();
        do_reset();
        drive(OP_EI); step();
        chk("R12 enabled", 32'(irq_en_o), 32'h1);
        irq_i = 1'b1; drive(OP_NOP);
        chk("R10 annul", 32'(exec_o), 32'h0);
        chk("R10 push", 32'(stk_push_o), 32'h1);
        chk("R10 push data", 32'(stk_wdata_o), 32'h1);
        step();
        chk("R10 vector", 32'(fetch_addr_o), 32'h4);
        chk("R10 shadow", 32'(shadow_o), 32'h1);
        chk("R10 enable off", 32'(irq_en_o), 32'h0);
        stk_rdata_i = 16'h0001; drive(OP_RTI);
        chk("R8 rti pop", 32'(stk_pop_o), 32'h1);
        step();
        chk("R8 shadow off", 32'(shadow_o), 32'h0);
        drive(OP_EI); step();
        chk("R8 rti return", 32'(fetch_addr_o), 32'h1);
        chk("R12 enable in slot", 32'(irq_en_o), 32'h1);
    endtask

    task automatic t_defer();
        do_reset();
        drive(OP_EI); step();
        reg_i = 16'h0020; drive(OP_JMP); step();
        irq_i = 1'b1; drive(OP_NOP);
        chk("R11 slot exec", 32'(exec_o), 32'h1);
        chk("R11 slot no push", 32'(stk_push_o), 32'h0);
        step();
        irq_i = 1'b1; drive(OP_NOP);
        chk("R11 at target", 32'(fetch_addr_o), 32'h0020);
        chk("R11 taken push", 32'(stk_push_o), 32'h1);
        chk("R11 taken data", 32'(stk_wdata_o), 32'h0020);
        step();
        chk("R11 vector", 32'(fetch_addr_o), 32'h4);
        do_reset();
        drive(OP_EI); step();
        drive(OP_DI); step();
        irq_i = 1'b1; drive(OP_NOP);
        chk("R12 disabled", 32'(irq_en_o), 32'h0);
        chk("R12 ignored exec", 32'(exec_o), 32'h1);
        chk("R12 ignored push", 32'(stk_push_o), 32'h0);
        step();
        chk("R12 ignored addr", 32'(fetch_addr_o), 32'h3);
    endtask

    task automatic t_halt();
        do_reset();
        drive(OP_HALT); step();
        for (int i = 0; i < 3; i++) begin
            drive(OP_NOP);
            chk("R9 parked addr", 32'(fetch_addr_o), 32'h1);
            chk("R9 parked exec", 32'(exec_o), 32'h0);
            step();
        end
        wake_i = 1'b1; drive(OP_NOP); step();
        chk("R9 woken addr", 32'(fetch_addr_o), 32'h1);
        chk("R9 woken exec", 32'(exec_o), 32'h1);
        do_reset();
        drive(OP_EI); step();
        drive(OP_HALT); step();
        irq_i = 1'b1; drive(OP_NOP);
        chk("R10 halt push", 32'(stk_push_o), 32'h1);
        chk("R10 halt data", 32'(stk_wdata_o), 32'h2);
        step();
        chk("R10 halt vector", 32'(fetch_addr_o), 32'h4);
    endtask

    initial begin
        t_reset();
        t_sequential();
        t_jump();
        t_relative();
        t_branch_not_taken();
        t_immediate();
        t_call_return();
        t_interrupt();
        t_defer();
        t_halt();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule